// File: doc/BRIEF.md
# Stuck Speed-Change Receiver Recovery Monitor

This block sits beside a PCI Express link controller and watches for one failure: a move to the faster signalling rate that has hung. The hang shows up as three things at once. The link is not reported as trained, meaning "up" is not set while "training" is clear. The 6-bit training-state code holds the receiver-lock value of the Recovery state. The PHY reports that its receiver data is not valid.

On a trigger the monitor first reads the PHY receive-status register to sample the valid flag. When the flag is clear, it forces a receiver restart through the PHY's indirect register port. It reads the receive override register, sets the data-enable and PLL-enable override bits, and writes the word back. It then waits a programmable hold time. After the wait it reads the register again, clears the same two bits and writes it back.

Every PHY access goes through a simple request/acknowledge master port. A one-cycle event pulse marks each completed recovery. A sticky error flag records any PHY access that reported a failure.

Top module: `rxlock_recovery_mon`

## Requirements
- R1: No PHY access starts while `link_up` is 1 and `link_training` is 0. When `link_up` is 1 and `link_training` is 1 together with the trigger code, this counts as not trained and does trigger.
- R2: A trigger needs `ltssm_code` equal to 6'h0D with the link not trained. Any other code (for example 6'h0C or 6'h2D) causes no PHY access.
- R3: The first access of a trigger reads PHY address 16'h100D. When bit 0 of the returned data is 1, the attempt ends with no further access. Only bit 0 is examined.
- R4: When that bit is 0, the block reads address 16'h1005 and then writes the returned value OR 16'h0028 to 16'h1005. Bit 5 is the data-enable override and bit 3 is the PLL-enable override.
- R5: Between the acknowledge of the setting write and the next request there are no fewer than HOLD_CYC and no more than HOLD_CYC+4 clock cycles with no PHY request.
- R6: After the hold, the block reads 16'h1005 again and writes the returned value AND NOT 16'h0028 back to 16'h1005.
- R7: Bits other than 5 and 3 are written back exactly as returned by the read that precedes each write. The clearing step uses the freshly read value, not the earlier one.
- R8: `phy_req` stays high with `phy_we`, `phy_addr` and `phy_wdata` stable until the cycle in which `phy_ack` is sampled high. Only one access is outstanding at a time.
- R9: An acknowledge with `phy_err` high ends the attempt with no further access and sets `recov_err`. `recov_err` stays set until reset, including across later successful recoveries.
- R10: `recov_event` is high for exactly one cycle after the clearing write of each recovery completes without error, and at no other time.
- R11: While an attempt is in progress, trigger conditions are ignored and cause no extra PHY access.
- R12: Under reset `phy_req`, `recov_event` and `recov_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link controller reports the link up |
| link_training | input | 1 | Link controller reports training in progress |
| ltssm_code | input | 6 | Current training-state code |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle acknowledge of the current access |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| phy_err | input | 1 | Access failed, valid with `phy_ack` |
| recov_event | output | 1 | One-cycle pulse per completed recovery |
| recov_err | output | 1 | Sticky PHY access error flag |

## Verification
The bench builds the block with HOLD_CYC = 20 in place of the millisecond-scale default, and its PHY model acknowledges three cycles after each request. A short hold lets the run measure the exact idle gap around the hold window. It also leaves room to re-raise the trigger code inside that window, and to repeat full recoveries with different override contents, a value changed between the two steps, and errors injected on chosen accesses. All of this fits in a few thousand cycles.

// File: rtl/rxlock_recovery_pkg.sv
package rxlock_recovery_pkg;

    localparam int PHY_AW   = 16;
    localparam int PHY_DW   = 16;
    localparam int LTSSM_W  = 6;

    localparam logic [LTSSM_W-1:0] RCVR_LOCK_CODE = 6'h0D;
    localparam logic [PHY_AW-1:0]  ADDR_RX_STATUS = 16'h100D;
    localparam logic [PHY_AW-1:0]  ADDR_RX_OVRD   = 16'h1005;
    localparam logic [PHY_DW-1:0]  OVRD_EN_MASK   = 16'h0028;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RXV,
        ST_RD_SET,
        ST_WR_SET,
        ST_HOLD,
        ST_RD_CLR,
        ST_WR_CLR
    } rcv_state_e;

    typedef struct packed {
        logic              we;
        logic [PHY_AW-1:0] addr;
        logic [PHY_DW-1:0] data;
    } phy_op_t;

    function automatic phy_op_t mk_read(input logic [PHY_AW-1:0] a);
        phy_op_t o;
        o.we   = 1'b0;
        o.addr = a;
        o.data = '0;
        return o;
    endfunction

    function automatic phy_op_t mk_write(input logic [PHY_AW-1:0] a,
                                         input logic [PHY_DW-1:0] d);
        phy_op_t o;
        o.we   = 1'b1;
        o.addr = a;
        o.data = d;
        return o;
    endfunction

endpackage

// File: rtl/rxlock_stuck_detect.sv
module rxlock_stuck_detect
    import rxlock_recovery_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               link_up,
    input  logic               link_training,
    input  logic [LTSSM_W-1:0] ltssm_code,
    output logic               stuck_q
);

    logic trained;
    assign trained = link_up && !link_training;

    always_ff @(posedge clk) begin
        if (rst) stuck_q <= 1'b0;
        else     stuck_q <= !trained && (ltssm_code == RCVR_LOCK_CODE);
    end

    // R2: a non-matching code never leaves a trigger behind
    p_code_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (ltssm_code != RCVR_LOCK_CODE) |=> !stuck_q);

    // R1: a trained link never leaves a trigger behind
    p_trained_gate_r1: assert property (@(posedge clk) disable iff (rst)
        (link_up && !link_training) |=> !stuck_q);

endmodule

// File: rtl/rxlock_hold_timer.sv
module rxlock_hold_timer #(
    parameter int HOLD_CYC = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    logic          running;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= CW'(HOLD_CYC - 1);
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign expired = running && (cnt == '0);

    // R5: the expiry is a single-cycle event
    p_expire_once_r5: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> !expired);

endmodule

// File: rtl/rxlock_phy_port.sv
module rxlock_phy_port
    import rxlock_recovery_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  phy_op_t           op,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [PHY_DW-1:0] phy_rdata,
    input  logic              phy_err,
    output logic              done,
    output logic              done_err,
    output logic [PHY_DW-1:0] done_data
);

    phy_op_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            phy_req   <= 1'b0;
            cur       <= '0;
            done      <= 1'b0;
            done_err  <= 1'b0;
            done_data <= '0;
        end else begin
            done <= 1'b0;
            if (issue) begin
                phy_req <= 1'b1;
                cur     <= op;
            end else if (phy_req && phy_ack) begin
                phy_req   <= 1'b0;
                done      <= 1'b1;
                done_err  <= phy_err;
                done_data <= phy_rdata;
            end
        end
    end

    assign phy_we    = cur.we;
    assign phy_addr  = cur.addr;
    assign phy_wdata = cur.data;

    // R8: request and its fields hold until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr)
                                   && $stable(phy_we) && $stable(phy_wdata)));

    // R8: never a second access while one is outstanding
    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        issue |-> !phy_req);

endmodule

// File: rtl/rxlock_recovery_mon.sv
module rxlock_recovery_mon
    import rxlock_recovery_pkg::*;
#(
    parameter int HOLD_CYC = 250000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               link_up,
    input  logic               link_training,
    input  logic [LTSSM_W-1:0] ltssm_code,
    output logic               phy_req,
    output logic               phy_we,
    output logic [PHY_AW-1:0]  phy_addr,
    output logic [PHY_DW-1:0]  phy_wdata,
    input  logic               phy_ack,
    input  logic [PHY_DW-1:0]  phy_rdata,
    input  logic               phy_err,
    output logic               recov_event,
    output logic               recov_err
);

    rcv_state_e        state, nxt;
    logic              stuck_q;
    logic              issue;
    phy_op_t           op;
    logic              done, done_err;
    logic [PHY_DW-1:0] done_data;
    logic              tmr_load, tmr_expired;
    logic              event_d, err_set;

    rxlock_stuck_detect u_detect (
        .clk           (clk),
        .rst           (rst),
        .link_up       (link_up),
        .link_training (link_training),
        .ltssm_code    (ltssm_code),
        .stuck_q       (stuck_q)
    );

    rxlock_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    rxlock_phy_port u_port (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .op        (op),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .phy_err   (phy_err),
        .done      (done),
        .done_err  (done_err),
        .done_data (done_data)
    );

    always_comb begin
        nxt      = state;
        issue    = 1'b0;
        op       = '0;
        tmr_load = 1'b0;
        event_d  = 1'b0;
        err_set  = 1'b0;
        unique case (state)
            ST_IDLE: if (stuck_q) begin
                issue = 1'b1;
                op    = mk_read(ADDR_RX_STATUS);
                nxt   = ST_RXV;
            end
            ST_RXV: if (done) begin
                if (done_err) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else if (done_data[0]) begin
                    nxt = ST_IDLE;
                end else begin
                    issue = 1'b1;
                    op    = mk_read(ADDR_RX_OVRD);
                    nxt   = ST_RD_SET;
                end
            end
            ST_RD_SET: if (done) begin
                if (done_err) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    issue = 1'b1;
                    op    = mk_write(ADDR_RX_OVRD, done_data | OVRD_EN_MASK);
                    nxt   = ST_WR_SET;
                end
            end
            ST_WR_SET: if (done) begin
                if (done_err) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    tmr_load = 1'b1;
                    nxt      = ST_HOLD;
                end
            end
            ST_HOLD: if (tmr_expired) begin
                issue = 1'b1;
                op    = mk_read(ADDR_RX_OVRD);
                nxt   = ST_RD_CLR;
            end
            ST_RD_CLR: if (done) begin
                if (done_err) begin
                    err_set = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    issue = 1'b1;
                    op    = mk_write(ADDR_RX_OVRD, done_data & ~OVRD_EN_MASK);
                    nxt   = ST_WR_CLR;
                end
            end
            ST_WR_CLR: if (done) begin
                if (done_err) err_set = 1'b1;
                else          event_d = 1'b1;
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            recov_event <= 1'b0;
            recov_err   <= 1'b0;
        end else begin
            state       <= nxt;
            recov_event <= event_d;
            recov_err   <= recov_err | err_set;
        end
    end

    // R1 / R11: idle without a trigger keeps the port quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !stuck_q) |=> !phy_req);

    // R4: the setting write carries both override enables
    p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_SET && phy_req) |->
            (phy_we && phy_addr == ADDR_RX_OVRD
             && (phy_wdata & OVRD_EN_MASK) == OVRD_EN_MASK));

    // R6: the clearing write carries neither override enable
    p_clr_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_CLR && phy_req) |->
            (phy_we && phy_addr == ADDR_RX_OVRD
             && (phy_wdata & OVRD_EN_MASK) == '0));

    // R5: nothing is requested during the hold window
    p_hold_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !phy_req);

    // R9: the error flag never falls outside reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        recov_err |=> recov_err);

    // R10: the completion event is one cycle wide
    p_event_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        recov_event |=> !recov_event);

endmodule

// File: tb/rxlock_recovery_mon_tb_top.sv
module rxlock_recovery_mon_tb_top;

    localparam int HOLD = 20;
    localparam int LAT  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic        link_training = 1'b0;
    logic [5:0]  ltssm_code = 6'h11;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        phy_err = 1'b0;
    logic        recov_event, recov_err;

    always #10 clk = ~clk;

    rxlock_recovery_mon #(.HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst(rst), .link_up(link_up), .link_training(link_training),
        .ltssm_code(ltssm_code), .phy_req(phy_req), .phy_we(phy_we),
        .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
        .phy_rdata(phy_rdata), .phy_err(phy_err),
        .recov_event(recov_event), .recov_err(recov_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard: {we, addr, data}
    logic [32:0] exp_q[$];
    logic [15:0] stat_reg = 16'h0001;
    logic [15:0] ovrd_reg = 16'h0000;
    logic [15:0] mutate   = 16'h0000;
    int          err_at   = -1;
    int          txn_no   = 0;
    int          cyc      = 0;
    int          lat      = 0;
    bit          in_txn   = 0;
    logic [32:0] cap;
    int          set_ack_cyc = -1;
    int          ev_cnt = 0;
    bit          ev_prev = 0;
    int          ev_wide = 0;

    task automatic push_rd(input logic [15:0] a);
        exp_q.push_back({1'b0, a, 16'h0000});
    endtask
    task automatic push_wr(input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back({1'b1, a, d});
    endtask

    // driver: full recovery expectation
    task automatic expect_recovery(input logic [15:0] v0, input logic [15:0] mut);
        logic [15:0] set_v;
        stat_reg = 16'hFFFE;
        ovrd_reg = v0;
        mutate   = mut;
        set_v    = v0 | 16'h0028;
        push_rd(16'h100D);
        push_rd(16'h1005);
        push_wr(16'h1005, set_v);
        push_rd(16'h1005);
        push_wr(16'h1005, (set_v ^ mut) & ~16'h0028);
    endtask

    // PHY model and monitor
    always @(negedge clk) begin
        cyc++;
        phy_ack = 1'b0;
        if (recov_event) begin
            ev_cnt++;
            if (ev_prev) ev_wide++;
        end
        ev_prev = recov_event;
        if (!rst && phy_req) begin
            if (!in_txn) begin
                in_txn = 1;
                lat    = 0;
                cap    = {phy_we, phy_addr, phy_wdata};
                if (set_ack_cyc >= 0) begin
                    chk((cyc - set_ack_cyc) >= HOLD && (cyc - set_ack_cyc) <= HOLD + 4,
                        "R5 hold gap", cyc - set_ack_cyc, HOLD);
                    set_ack_cyc = -1;
                end
            end else if (cap != {phy_we, phy_addr, phy_wdata}) begin
                chk(0, "R8 request changed before ack",
                    int'({phy_we, phy_addr, phy_wdata}), int'(cap));
            end
            lat++;
            if (lat == LAT) begin
                logic [32:0] e;
                in_txn  = 0;
                phy_ack = 1'b1;
                phy_err = (txn_no == err_at);
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected PHY access", int'(cap), 0);
                end else begin
                    e = exp_q.pop_front();
                    if (e[32]) chk(cap == e, "R4/R6/R7 access", int'(cap), int'(e));
                    else       chk(cap[32:16] == e[32:16], "R3/R4/R6 read access",
                                   int'(cap[32:16]), int'(e[32:16]));
                end
                if (phy_we) begin
                    if (phy_addr == 16'h1005) begin
                        if ((phy_wdata & 16'h0028) == 16'h0028) begin
                            ovrd_reg = phy_wdata ^ mutate;
                            if (!phy_err) set_ack_cyc = cyc;
                        end else begin
                            ovrd_reg = phy_wdata;
                        end
                    end
                    phy_rdata = 16'h0000;
                end else begin
                    phy_rdata = (phy_addr == 16'h100D) ? stat_reg :
                                (phy_addr == 16'h1005) ? ovrd_reg : 16'hDEAD;
                end
                txn_no++;
            end
        end
    end

    task automatic kick();
        ltssm_code = 6'h0D;
        for (int i = 0; i < 200 && !phy_req; i++) @(negedge clk);
        ltssm_code = 6'h11;
    endtask

    task automatic settle();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int t0, e0;
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(phy_req == 1'b0, "R12 req in reset", phy_req, 0);
        chk(recov_event == 1'b0, "R12 event in reset", recov_event, 0);
        chk(recov_err == 1'b0, "R12 err in reset", recov_err, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: trained link with trigger code: no access
        t0 = txn_no;
        link_up = 1'b1; link_training = 1'b0; ltssm_code = 6'h0D;
        repeat (30) @(negedge clk);
        ltssm_code = 6'h11;
        settle();
        chk(txn_no == t0, "R1 trained link ignored", txn_no - t0, 0);

        // R2: other codes with link down: no access
        link_up = 1'b0;
        ltssm_code = 6'h0C;
        repeat (30) @(negedge clk);
        ltssm_code = 6'h2D;
        repeat (30) @(negedge clk);
        ltssm_code = 6'h11;
        settle();
        chk(txn_no == t0, "R2 other codes ignored", txn_no - t0, 0);

        // R3: receive-valid set: one status read only
        stat_reg = 16'h0001;
        push_rd(16'h100D);
        e0 = ev_cnt;
        kick();
        settle();
        chk(txn_no == t0 + 1, "R3 stop after valid read", txn_no - t0, 1);
        chk(ev_cnt == e0, "R3 no event", ev_cnt - e0, 0);

        // R1/R4/R6/R10: up-but-training counts as untrained; full recovery
        link_up = 1'b1; link_training = 1'b1;
        t0 = txn_no;
        expect_recovery(16'h1234, 16'h0000);
        kick();
        settle();
        chk(txn_no == t0 + 5, "R4 R6 full recovery access count", txn_no - t0, 5);
        chk(ev_cnt == e0 + 1, "R10 one event", ev_cnt - e0, 1);
        chk(ovrd_reg == 16'h1214, "R7 override restored", ovrd_reg, 16'h1214);

        // R7/R11: value changes during hold; trigger re-raised during hold
        link_up = 1'b0;
        t0 = txn_no;
        expect_recovery(16'h0000, 16'h8001);
        kick();
        for (int i = 0; i < 500 && set_ack_cyc < 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        ltssm_code = 6'h0D;
        repeat (5) @(negedge clk);
        ltssm_code = 6'h11;
        settle();
        chk(txn_no == t0 + 5, "R11 no extra access during recovery", txn_no - t0, 5);
        chk(ovrd_reg == 16'h8001, "R7 fresh value cleared", ovrd_reg, 16'h8001);
        chk(ev_cnt == e0 + 2, "R10 second event", ev_cnt - e0, 2);

        // all bits set in the override register
        t0 = txn_no;
        expect_recovery(16'hFFFF, 16'h0000);
        kick();
        settle();
        chk(ovrd_reg == 16'hFFD7, "R6 all-ones cleared", ovrd_reg, 16'hFFD7);
        chk(recov_err == 1'b0, "R9 no error yet", recov_err, 0);

        // R9: error on the setting write ends the attempt
        t0 = txn_no;
        stat_reg = 16'h0000;
        ovrd_reg = 16'h0100;
        err_at = txn_no + 2;
        push_rd(16'h100D);
        push_rd(16'h1005);
        push_wr(16'h1005, 16'h0128);
        e0 = ev_cnt;
        kick();
        settle();
        err_at = -1;
        set_ack_cyc = -1;
        chk(txn_no == t0 + 3, "R9 stop after error", txn_no - t0, 3);
        chk(recov_err == 1'b1, "R9 error flag set", recov_err, 1);
        chk(ev_cnt == e0, "R10 no event on error", ev_cnt - e0, 0);

        // R9: flag survives a good recovery
        expect_recovery(16'h0040, 16'h0000);
        kick();
        settle();
        chk(recov_err == 1'b1, "R9 flag sticky", recov_err, 1);
        chk(ev_cnt == e0 + 1, "R10 event after good run", ev_cnt - e0, 1);

        // R9: error on the status read
        t0 = txn_no;
        err_at = txn_no;
        push_rd(16'h100D);
        kick();
        settle();
        err_at = -1;
        chk(txn_no == t0 + 1, "R9 stop after status error", txn_no - t0, 1);

        chk(ev_wide == 0, "R10 event single cycle", ev_wide, 0);

        // R12: reset clears the flag
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(recov_err == 1'b0, "R12 reset clears error", recov_err, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end

endmodule